// File: doc/BRIEF.md
# Root Port Error Status Collector

This block sits inside a root port and gathers the error messages that arrive from the hierarchy below it. Each message carries a severity (correctable, non-fatal or fatal) and a 16-bit requester identifier of the function that sent it. The block keeps a set of sticky status flags that software clears by writing ones. These flags record that a message of each class arrived, that more than one arrived, and whether the first uncorrectable message was fatal. It also keeps the identifier of the first correctable sender and the first uncorrectable sender.

A three-bit command register enables interrupt generation per severity. The interrupt behaves differently depending on the delivery mode. In message mode (MSI or MSI-X), the block emits a single one-cycle request each time the combined pending condition rises from false to true. In legacy mode, the request is a level that follows the pending condition. An internal control path loads the interrupt message number, which software can read but not write.

Top module: `rp_err_collector`

## Requirements
- R1: After reset, the command register, every status flag, both captured identifiers, the message number and `irq` are zero.
- R2: A correctable message (`msg_sev` = 0) sets flag bit 0. It stores `msg_src` in `src_cor` only if bit 0 was clear. Otherwise it sets flag bit 1 and leaves `src_cor` unchanged.
- R3: A non-fatal (`msg_sev` = 1) or fatal (`msg_sev` = 2) message sets flag bit 2. It stores `msg_src` in `src_uncor` only if bit 2 was clear. Otherwise it sets flag bit 3 and leaves `src_uncor` unchanged.
- R4: A non-fatal message sets flag bit 5. A fatal message sets flag bit 6, and sets flag bit 4 only if flag bit 2 was clear before that message.
- R5: A status write clears every flag whose `sts_wdata` bit is one and leaves the others alone. When a write and a message arrive in the same cycle, the write is applied first and the message second.
- R6: In legacy mode (`msi_mode` = 0), `irq` equals the OR of three terms: flag 0 AND command bit 0, flag 5 AND command bit 1, and flag 6 AND command bit 2. It follows every change to the flags or the command register.
- R7: In message mode, a message that turns the pending OR from false to true produces `irq` high for exactly one cycle.
- R8: In message mode, a command write that turns the pending OR from false to true produces the same one-cycle pulse. Command writes are visible on `root_cmd` one cycle later.
- R9: In message mode, no pulse is produced while the pending OR was already true, even when further messages arrive or further enables are set.
- R10: `msg_sev` = 3 is ignored and changes no output. `num_we` loads `int_num`, and no other input changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | An error message is present this cycle |
| msg_sev | input | 2 | Message severity: 0 correctable, 1 non-fatal, 2 fatal, 3 ignored |
| msg_src | input | 16 | Requester identifier carried by the message |
| cmd_we | input | 1 | Write the command register |
| cmd_wdata | input | 3 | Enables: bit 0 correctable, bit 1 non-fatal, bit 2 fatal |
| sts_we | input | 1 | Write-one-to-clear access to the status flags |
| sts_wdata | input | 7 | Flags to clear |
| msi_mode | input | 1 | 1: message interrupt delivery, 0: legacy level |
| num_we | input | 1 | Internal load of the interrupt message number |
| num_wdata | input | 5 | Message number value |
| root_cmd | output | 3 | Command register |
| root_sts | output | 7 | Status flags (bit meanings in R2 to R4) |
| int_num | output | 5 | Interrupt message number |
| src_cor | output | 16 | First correctable sender |
| src_uncor | output | 16 | First uncorrectable sender |
| irq | output | 1 | Interrupt request: pulse in message mode, level in legacy mode |

## Verification
Every piece of state is either an output or feeds `irq` directly. A wrong flag, identifier or enable therefore appears at the ports one clock after the message or write that caused it. The subtler failures are in the history: a missed "already received" test overwrites a captured identifier or drops a multiple flag only on the second message of a class. A wrong pending comparison shows up as a missing or repeated pulse only on the cycle the condition rises. The stimulus therefore mixes repeated messages of each class with clears, enable changes and mode changes, and compares all outputs every cycle against a reference model.

// File: rtl/rp_err_collector.sv
module rp_err_collector #(
  parameter int SRC_W = 16,
  parameter int NUM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  logic [1:0]       msg_sev,
  input  logic [SRC_W-1:0] msg_src,
  input  logic             cmd_we,
  input  logic [2:0]       cmd_wdata,
  input  logic             sts_we,
  input  logic [6:0]       sts_wdata,
  input  logic             msi_mode,
  input  logic             num_we,
  input  logic [NUM_W-1:0] num_wdata,
  output logic [2:0]       root_cmd,
  output logic [6:0]       root_sts,
  output logic [NUM_W-1:0] int_num,
  output logic [SRC_W-1:0] src_cor,
  output logic [SRC_W-1:0] src_uncor,
  output logic             irq
);
  localparam int F_COR   = 0;
  localparam int F_MCOR  = 1;
  localparam int F_UNC   = 2;
  localparam int F_MUNC  = 3;
  localparam int F_FIRST = 4;
  localparam int F_NFAT  = 5;
  localparam int F_FAT   = 6;
  localparam logic [1:0] SEV_COR = 2'd0, SEV_NFAT = 2'd1, SEV_FAT = 2'd2;

  logic [6:0]       sts_mid, sts_nxt;
  logic [2:0]       cmd_nxt;
  logic [SRC_W-1:0] cor_nxt, unc_nxt;
  logic             pend_mid, pend_nxt, pend_q, pulse_q;

  function automatic logic pending(input logic [6:0] s, input logic [2:0] c);
    return (s[F_COR] & c[0]) | (s[F_NFAT] & c[1]) | (s[F_FAT] & c[2]);
  endfunction

  always_comb begin
    sts_mid = root_sts & ~(sts_we ? sts_wdata : 7'd0);
    sts_nxt = sts_mid;
    cmd_nxt = cmd_we ? cmd_wdata : root_cmd;
    cor_nxt = src_cor;
    unc_nxt = src_uncor;
    if (msg_valid && msg_sev == SEV_COR) begin
      if (sts_mid[F_COR]) sts_nxt[F_MCOR] = 1'b1;
      else                cor_nxt = msg_src;
      sts_nxt[F_COR] = 1'b1;
    end
    if (msg_valid && (msg_sev == SEV_NFAT || msg_sev == SEV_FAT)) begin
      if (msg_sev == SEV_FAT) begin
        if (!sts_mid[F_UNC]) sts_nxt[F_FIRST] = 1'b1;
        sts_nxt[F_FAT] = 1'b1;
      end else begin
        sts_nxt[F_NFAT] = 1'b1;
      end
      if (sts_mid[F_UNC]) sts_nxt[F_MUNC] = 1'b1;
      else                unc_nxt = msg_src;
      sts_nxt[F_UNC] = 1'b1;
    end
  end

  assign pend_mid = pending(sts_mid, root_cmd);
  assign pend_nxt = pending(sts_nxt, cmd_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      root_cmd  <= '0;
      root_sts  <= '0;
      int_num   <= '0;
      src_cor   <= '0;
      src_uncor <= '0;
      pend_q    <= 1'b0;
      pulse_q   <= 1'b0;
    end else begin
      root_cmd  <= cmd_nxt;
      root_sts  <= sts_nxt;
      src_cor   <= cor_nxt;
      src_uncor <= unc_nxt;
      pend_q    <= pend_nxt;
      pulse_q   <= msi_mode && !pend_mid && pend_nxt;
      if (num_we) int_num <= num_wdata;
    end
  end

  assign irq = msi_mode ? pulse_q : pend_q;

  assert_src_cor_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (root_sts[F_COR] && !(sts_we && sts_wdata[F_COR])) |=> $stable(src_cor));

  assert_src_unc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (root_sts[F_UNC] && !(sts_we && sts_wdata[F_UNC])) |=> $stable(src_uncor));

  assert_no_first_fatal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == SEV_FAT && root_sts[F_UNC] && !root_sts[F_FIRST] && !sts_we)
      |=> !root_sts[F_FIRST]);

  assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_we && sts_wdata[F_FAT] && !(msg_valid && msg_sev == SEV_FAT)) |=> !root_sts[F_FAT]);

  assert_pulse_has_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> pend_q);

  assert_ignored_sev_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == 2'd3 && !sts_we && !cmd_we) |=> $stable(root_sts));
endmodule

// File: tb/rp_err_collector_bench.sv
module rp_err_collector_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic [1:0]  msg_sev = '0;
  logic [15:0] msg_src = '0;
  logic        cmd_we = 1'b0;
  logic [2:0]  cmd_wdata = '0;
  logic        sts_we = 1'b0;
  logic [6:0]  sts_wdata = '0;
  logic        msi_mode = 1'b0;
  logic        num_we = 1'b0;
  logic [4:0]  num_wdata = '0;
  logic [2:0]  root_cmd;
  logic [6:0]  root_sts;
  logic [4:0]  int_num;
  logic [15:0] src_cor, src_uncor;
  logic        irq;

  int vectors = 0, errors = 0;
  bit done = 0;

  logic [2:0]  e_cmd;
  logic [6:0]  e_sts;
  logic [4:0]  e_num;
  logic [15:0] e_cor, e_unc;
  logic        e_irq;

  always #10 clk = ~clk;

  rp_err_collector u_rp_err_collector (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_sev(msg_sev), .msg_src(msg_src),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .sts_we(sts_we), .sts_wdata(sts_wdata),
    .msi_mode(msi_mode), .num_we(num_we), .num_wdata(num_wdata),
    .root_cmd(root_cmd), .root_sts(root_sts), .int_num(int_num),
    .src_cor(src_cor), .src_uncor(src_uncor), .irq(irq));

  function automatic logic pend_of(input logic [6:0] s, input logic [2:0] c);
    return (s[0] && c[0]) || (s[5] && c[1]) || (s[6] && c[2]);
  endfunction

  task automatic chk(input string req, input string fld, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, fld, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "root_cmd R8", {13'd0, root_cmd}, {13'd0, e_cmd});
    chk(tag, "root_sts R4", {9'd0, root_sts}, {9'd0, e_sts});
    chk(tag, "src_cor R2", src_cor, e_cor);
    chk(tag, "src_uncor R3", src_uncor, e_unc);
    chk(tag, "int_num R10", {11'd0, int_num}, {11'd0, e_num});
    chk(tag, msi_mode ? "irq R7" : "irq R6", {15'd0, irq}, {15'd0, e_irq});
  endtask

  task automatic step(input string tag);
    logic [6:0] s;
    logic [2:0] c;
    logic [15:0] co, un;
    logic mid;
    s = e_sts & ~(sts_we ? sts_wdata : 7'd0);
    mid = pend_of(s, e_cmd);
    c = cmd_we ? cmd_wdata : e_cmd;
    co = e_cor; un = e_unc;
    if (msg_valid && msg_sev == 2'd0) begin
      if (s[0]) s[1] = 1'b1; else co = msg_src;
      s[0] = 1'b1;
    end else if (msg_valid && msg_sev != 2'd3) begin
      if (msg_sev == 2'd2) begin
        if (!s[2]) s[4] = 1'b1;
        s[6] = 1'b1;
      end else s[5] = 1'b1;
      if (s[2]) s[3] = 1'b1; else un = msg_src;
      s[2] = 1'b1;
    end
    e_irq = msi_mode ? (!mid && pend_of(s, c)) : pend_of(s, c);
    if (num_we) e_num = num_wdata;
    e_sts = s; e_cmd = c; e_cor = co; e_unc = un;
    @(posedge clk);
    @(negedge clk);
    msg_valid = 0; cmd_we = 0; sts_we = 0; num_we = 0;
    check_all(tag);
  endtask

  task automatic send(input logic [1:0] sev, input logic [15:0] src, input string tag);
    msg_valid = 1; msg_sev = sev; msg_src = src;
    step(tag);
  endtask

  task automatic wcmd(input logic [2:0] v, input string tag);
    cmd_we = 1; cmd_wdata = v;
    step(tag);
  endtask

  task automatic wclr(input logic [6:0] v, input string tag);
    sts_we = 1; sts_wdata = v;
    step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    e_cmd = 0; e_sts = 0; e_num = 0; e_cor = 0; e_unc = 0; e_irq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check_all("R1");

    send(2'd0, 16'hA5A5, "R2");
    chk("R2", "first cor src", src_cor, 16'hA5A5);
    send(2'd0, 16'h1111, "R2");
    chk("R2", "multi cor flags", {9'd0, root_sts}, 16'h0003);
    send(2'd1, 16'h2222, "R3");
    chk("R3", "first uncor src", src_uncor, 16'h2222);
    send(2'd2, 16'h3333, "R4");
    chk("R4", "fatal after nonfatal", {9'd0, root_sts}, 16'h006F);
    sts_we = 1; sts_wdata = 7'h7F;
    send(2'd2, 16'h4444, "R5");
    chk("R5", "clear then fatal", {9'd0, root_sts}, 16'h0054);
    chk("R5", "src after clear", src_uncor, 16'h4444);
    send(2'd3, 16'h9999, "R10");
    chk("R10", "ignored sev", {9'd0, root_sts}, 16'h0054);
    num_we = 1; num_wdata = 5'h15;
    step("R10");
    chk("R10", "msg number", {11'd0, int_num}, 16'h0015);

    wcmd(3'b100, "R6");
    chk("R6", "legacy level on", {15'd0, irq}, 16'd1);
    wclr(7'h40, "R6");
    chk("R6", "legacy level off", {15'd0, irq}, 16'd0);

    msi_mode = 1;
    wclr(7'h7F, "R7");
    wcmd(3'b001, "R7");
    send(2'd0, 16'h0101, "R7");
    chk("R7", "msi pulse", {15'd0, irq}, 16'd1);
    step("R7");
    chk("R7", "pulse one cycle", {15'd0, irq}, 16'd0);
    send(2'd0, 16'h0202, "R9");
    wcmd(3'b011, "R9");
    send(2'd1, 16'h0303, "R9");
    chk("R9", "no repeat pulse", {15'd0, irq}, 16'd0);
    wclr(7'h7F, "R8");
    wcmd(3'b000, "R8");
    send(2'd2, 16'h0404, "R8");
    chk("R8", "disabled no pulse", {15'd0, irq}, 16'd0);
    wcmd(3'b100, "R8");
    chk("R8", "cmd write pulse", {15'd0, irq}, 16'd1);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      msg_valid = r[0] | r[1];
      msg_sev = r[3:2];
      msg_src = r[19:4];
      cmd_we = (r[23:20] == 4'd0);
      cmd_wdata = r[26:24];
      sts_we = (r[30:27] < 4'd3);
      sts_wdata = 7'($urandom);
      num_we = (r[31] && r[5:4] == 2'd0);
      num_wdata = 5'($urandom);
      if (($urandom % 64) == 0) msi_mode = ~msi_mode;
      step("RND");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule